// File: doc/BRIEF.md
# UART Prioritized Interrupt Controller

This block gathers every interrupt condition of a single UART channel, applies the per-source enable bits, and reports the most urgent pending condition as a 6-bit code on a read-only status port. A single active-high interrupt line is raised whenever at least one enabled condition is pending. The FIFOs, the baud timing, the serial shifters, the idle timer and the character comparators sit outside. They feed this block with level signals, such as FIFO fill levels and triggers, and with one-cycle event strobes, such as error flags, modem deltas, time-out and character detects.

Software reads the status code to find out what to service. It then performs the access that clears that condition: a line-status read, a modem-status read, a receive-holding read, a transmit-holding write, or, for some sources, the status read itself. Pending conditions of lower priority stay latched and appear in the code once the higher ones are gone. Flow-control edges on the CTS input and the RTS output form a seventh, lowest level with code 0x20.

Top module: `uart_irq_prio`

## Requirements
- R1: After a synchronous active-low reset with idle inputs, `isr_code` reads 0x01 and `irq` is low.
- R2: Enabled pending sources are reported with this priority and these codes: line status 0x06, receive time-out 0x0C, receive ready 0x04, transmit ready 0x02, modem status 0x00, Xoff/special 0x10, flow-control edge 0x20. The code is 0x01 when nothing is pending.
- R3: A nonzero `lsr_evt` latches the line-status source, and an `lsr_rd` clears it. An event in the same cycle as the read keeps it pending.
- R4: Receive ready is a level, pending exactly while `rx_level >= rx_trig`, and is not latched.
- R5: An `rxto_evt` strobe latches the receive time-out source until `rhr_rd`.
- R6: Transmit ready latches on a rising edge of its condition. The condition is `tx_level <= tx_trig` normally and `tx_level == 0 && tsr_empty` when `rs485_en` is 1. It clears on `thr_wr`, or on `isr_rd` in a cycle where `isr_code` is 0x02. A new edge wins over a clear.
- R7: An `isr_rd` while a higher source is being reported leaves transmit ready and Xoff/special pending.
- R8: A nonzero `msr_evt` latches the modem source until `msr_rd`.
- R9: `xoff_det` latches a pending flag that `xon_det` clears. `spec_det` latches a pending flag that a later `rx_char` clears, and `spec_det` wins over `rx_char` in the same cycle. An `isr_rd` while 0x10 is reported clears both flags.
- R10: A low-to-high change on `cts_pin` while `auto_cts` is 1, or on `rts_pin` while `auto_rts` is 1, latches a flow-control source that `msr_rd` clears. No edge is seen in the first cycle after reset.
- R11: `ien` bit 0 enables both receive sources, bit 1 transmit, bit 2 line status, bit 3 modem, bit 4 Xoff/special, bit 5 RTS edge and bit 6 CTS edge. A source keeps latching while disabled, and becomes visible once it is enabled. `irq` is high exactly when `isr_code` is not 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ien | input | 7 | Source enable bits |
| lsr_evt | input | 4 | Line error event strobes |
| rxto_evt | input | 1 | Receive idle time-out strobe |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trig | input | LVL_W | Receive trigger level |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| tx_trig | input | LVL_W | Transmit trigger level |
| rs485_en | input | 1 | Half-duplex direction mode |
| tsr_empty | input | 1 | Transmit shifter empty |
| msr_evt | input | 4 | Modem delta event strobes |
| xoff_det | input | 1 | Xoff character received |
| xon_det | input | 1 | Xon character received |
| spec_det | input | 1 | Special character received |
| rx_char | input | 1 | Any character received |
| cts_pin | input | 1 | CTS input level |
| rts_pin | input | 1 | RTS output level |
| auto_cts | input | 1 | Automatic CTS flow control on |
| auto_rts | input | 1 | Automatic RTS flow control on |
| isr_rd | input | 1 | Status register read strobe |
| lsr_rd | input | 1 | Line status read strobe |
| msr_rd | input | 1 | Modem status read strobe |
| rhr_rd | input | 1 | Receive holding read strobe |
| thr_wr | input | 1 | Transmit holding write strobe |
| isr_code | output | 6 | Highest pending source code |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `FIFO_DEPTH` set to 16, so the level ports are 5 bits wide. This brings the full-FIFO level, the trigger-equality boundary and an empty transmit FIFO within a handful of values. A shallow depth also lets transmit-ready edges be produced by moving the level one step across the trigger, and lets the half-duplex mode be checked by holding the level at zero and toggling only the shifter flag.

// File: rtl/uart_irq_pkg.sv
// Package: shared source indices, enable bit positions and status codes
// for the UART interrupt prioritizer. Index 0 is the highest priority.
package uart_irq_pkg;
    localparam int NSRC = 7;

    // Source indices in priority order (0 = most urgent)
    localparam int SRC_LINE  = 0;
    localparam int SRC_RXTO  = 1;
    localparam int SRC_RXRDY = 2;
    localparam int SRC_TXRDY = 3;
    localparam int SRC_MODEM = 4;
    localparam int SRC_XCHR  = 5;
    localparam int SRC_FLOW  = 6;

    // Enable bit positions
    localparam int IEN_W     = 7;
    localparam int IEN_RX    = 0;
    localparam int IEN_TX    = 1;
    localparam int IEN_LINE  = 2;
    localparam int IEN_MODEM = 3;
    localparam int IEN_XCHR  = 4;
    localparam int IEN_RTS   = 5;
    localparam int IEN_CTS   = 6;

    localparam int CODE_W = 6;
    localparam logic [CODE_W-1:0] CODE_NONE = 6'h01;

    // Code per source index, element 0 at the right
    localparam logic [NSRC-1:0][CODE_W-1:0] SRC_CODE =
        {6'h20, 6'h10, 6'h00, 6'h02, 6'h04, 6'h0C, 6'h06};
endpackage

// File: rtl/uart_irq_rise.sv
// Module: uart_irq_rise
// Detects low-to-high changes on W independent level inputs.
// Assumes: the inputs are synchronous to clk. The history is reset to all
// ones, so no edge is reported in the first cycle after reset.
module uart_irq_rise #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] lvl_q;

    // Keep the previous cycle's levels
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '1;
        else        lvl_q <= lvl;
    end

    // Edge is present level high and previous level low
    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/uart_irq_src.sv
// Module: uart_irq_src
// Holds the sticky pending flag of every latched source, applies the
// clearing rules and the enable mask, and outputs one active bit per
// priority level. Receive-ready is a level and is not latched.
// Assumes: event and access strobes last one cycle. A set beats a clear
// in the same cycle.
module uart_irq_src
    import uart_irq_pkg::*;
#(
    parameter int LVL_W = 8,
    parameter int N_LSR = 4,
    parameter int N_MSR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IEN_W-1:0]  ien,
    input  logic [N_LSR-1:0]  lsr_evt,
    input  logic              rxto_evt,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  rx_trig,
    input  logic              tx_rise,
    input  logic [N_MSR-1:0]  msr_evt,
    input  logic              xoff_det,
    input  logic              xon_det,
    input  logic              spec_det,
    input  logic              rx_char,
    input  logic              cts_rise,
    input  logic              rts_rise,
    input  logic              lsr_rd,
    input  logic              rhr_rd,
    input  logic              msr_rd,
    input  logic              thr_wr,
    input  logic              ack_tx,
    input  logic              ack_x,
    output logic [NSRC-1:0]   act
);
    logic p_line, p_rxto, p_tx, p_msr, p_xoff, p_spec, p_cts, p_rts;

    // Line errors: sticky until the line status read
    always_ff @(posedge clk) begin
        if (!rst_n) p_line <= 1'b0;
        else        p_line <= (|lsr_evt) | (p_line & ~lsr_rd);
    end

    // Receive idle time-out: sticky until the holding register read
    always_ff @(posedge clk) begin
        if (!rst_n) p_rxto <= 1'b0;
        else        p_rxto <= rxto_evt | (p_rxto & ~rhr_rd);
    end

    // Transmit ready: edge set, cleared by a write or an acknowledging status read
    always_ff @(posedge clk) begin
        if (!rst_n) p_tx <= 1'b0;
        else        p_tx <= tx_rise | (p_tx & ~(thr_wr | ack_tx));
    end

    // Modem deltas: sticky until the modem status read
    always_ff @(posedge clk) begin
        if (!rst_n) p_msr <= 1'b0;
        else        p_msr <= (|msr_evt) | (p_msr & ~msr_rd);
    end

    // Xoff seen: cleared by Xon or an acknowledging status read
    always_ff @(posedge clk) begin
        if (!rst_n) p_xoff <= 1'b0;
        else        p_xoff <= xoff_det | (p_xoff & ~(xon_det | ack_x));
    end

    // Special character seen: cleared by the next character or a status read
    always_ff @(posedge clk) begin
        if (!rst_n) p_spec <= 1'b0;
        else        p_spec <= spec_det | (p_spec & ~(rx_char | ack_x));
    end

    // Flow-control edges: sticky until the modem status read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_cts <= 1'b0;
            p_rts <= 1'b0;
        end else begin
            p_cts <= cts_rise | (p_cts & ~msr_rd);
            p_rts <= rts_rise | (p_rts & ~msr_rd);
        end
    end

    // Mask pending flags with their enables, one bit per priority level
    always_comb begin
        act            = '0;
        act[SRC_LINE]  = p_line & ien[IEN_LINE];
        act[SRC_RXTO]  = p_rxto & ien[IEN_RX];
        act[SRC_RXRDY] = (rx_level >= rx_trig) & ien[IEN_RX];
        act[SRC_TXRDY] = p_tx & ien[IEN_TX];
        act[SRC_MODEM] = p_msr & ien[IEN_MODEM];
        act[SRC_XCHR]  = (p_xoff | p_spec) & ien[IEN_XCHR];
        act[SRC_FLOW]  = (p_cts & ien[IEN_CTS]) | (p_rts & ien[IEN_RTS]);
    end
endmodule

// File: rtl/uart_irq_prienc.sv
// Module: uart_irq_prienc
// Fixed-priority encoder: returns the code of the lowest-index active
// level, or the no-interrupt code when none is active.
// Assumes: the code table in the package is ordered by index.
module uart_irq_prienc
    import uart_irq_pkg::*;
(
    input  logic [NSRC-1:0]   act,
    output logic [CODE_W-1:0] code
);
    logic [NSRC:0][CODE_W-1:0] chain;

    assign chain[NSRC] = CODE_NONE;

    // Each stage overrides the result of all lower-priority stages
    for (genvar i = 0; i < NSRC; i++) begin : g_stage
        assign chain[i] = act[i] ? SRC_CODE[i] : chain[i+1];
    end

    assign code = chain[0];
endmodule

// File: rtl/uart_irq_prio.sv
// Module: uart_irq_prio (top)
// Interrupt prioritizer of one UART channel. Builds the transmit-ready
// condition, detects edges, latches the sources and encodes the most
// urgent enabled one. isr_code and irq are combinational from state and
// levels, so a status read sees the code of its own cycle.
// Assumes: all inputs are synchronous to clk and strobes last one cycle.
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter  int FIFO_DEPTH = 128,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IEN_W-1:0]   ien,
    input  logic [3:0]         lsr_evt,
    input  logic               rxto_evt,
    input  logic [LVL_W-1:0]   rx_level,
    input  logic [LVL_W-1:0]   rx_trig,
    input  logic [LVL_W-1:0]   tx_level,
    input  logic [LVL_W-1:0]   tx_trig,
    input  logic               rs485_en,
    input  logic               tsr_empty,
    input  logic [3:0]         msr_evt,
    input  logic               xoff_det,
    input  logic               xon_det,
    input  logic               spec_det,
    input  logic               rx_char,
    input  logic               cts_pin,
    input  logic               rts_pin,
    input  logic               auto_cts,
    input  logic               auto_rts,
    input  logic               isr_rd,
    input  logic               lsr_rd,
    input  logic               msr_rd,
    input  logic               rhr_rd,
    input  logic               thr_wr,
    output logic [CODE_W-1:0]  isr_code,
    output logic               irq
);
    logic            tx_cond;
    logic [2:0]      rise;
    logic [NSRC-1:0] act;
    logic            ack_tx, ack_x;

    // Transmit-ready condition: shifter-and-FIFO empty in half-duplex mode
    assign tx_cond = rs485_en ? ((tx_level == '0) & tsr_empty)
                              : (tx_level <= tx_trig);

    uart_irq_rise #(.W(3)) u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({rts_pin, cts_pin, tx_cond}),
        .rise  (rise)
    );

    // Status read acknowledges only the source it is reporting
    assign ack_tx = isr_rd & (isr_code == SRC_CODE[SRC_TXRDY]);
    assign ack_x  = isr_rd & (isr_code == SRC_CODE[SRC_XCHR]);

    uart_irq_src #(.LVL_W(LVL_W), .N_LSR(4), .N_MSR(4)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .ien      (ien),
        .lsr_evt  (lsr_evt),
        .rxto_evt (rxto_evt),
        .rx_level (rx_level),
        .rx_trig  (rx_trig),
        .tx_rise  (rise[0]),
        .msr_evt  (msr_evt),
        .xoff_det (xoff_det),
        .xon_det  (xon_det),
        .spec_det (spec_det),
        .rx_char  (rx_char),
        .cts_rise (rise[1] & auto_cts),
        .rts_rise (rise[2] & auto_rts),
        .lsr_rd   (lsr_rd),
        .rhr_rd   (rhr_rd),
        .msr_rd   (msr_rd),
        .thr_wr   (thr_wr),
        .ack_tx   (ack_tx),
        .ack_x    (ack_x),
        .act      (act)
    );

    uart_irq_prienc u_enc (
        .act  (act),
        .code (isr_code)
    );

    // Request line follows any enabled pending level
    assign irq = |act;
endmodule

// File: rtl/uart_irq_prio_chk.sv
// Module: uart_irq_prio_chk
// Property checker for uart_irq_prio, attached by bind. It observes
// the top-level ports only.
module uart_irq_prio_chk #(
    parameter int LVL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [6:0]       ien,
    input logic [3:0]       lsr_evt,
    input logic [3:0]       msr_evt,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] rx_trig,
    input logic             cts_pin,
    input logic             auto_cts,
    input logic [5:0]       isr_code,
    input logic             irq
);
    // R2
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isr_code inside {6'h01, 6'h06, 6'h0C, 6'h04, 6'h02, 6'h00, 6'h10, 6'h20});

    // R11
    irq_matches_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (isr_code != 6'h01));

    // R3
    line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|lsr_evt) && ien[2]) |=> (!ien[2] || isr_code == 6'h06));

    // R4
    rx_level_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien[0] && rx_level >= rx_trig) |-> isr_code inside {6'h06, 6'h0C, 6'h04});

    // R8
    modem_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|msr_evt) && ien[3]) |=> (!ien[3] || irq));

    // R10
    cts_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && auto_cts && ien[6] && cts_pin && !$past(cts_pin))
            |=> (!ien[6] || irq));
endmodule

bind uart_irq_prio uart_irq_prio_chk #(.LVL_W(LVL_W)) u_chk (.*);

// File: tb/uart_irq_prio_tb.sv
`timescale 1ns/1ps
// Bench for uart_irq_prio: a behavioural reference model advanced on every
// clock and compared against isr_code and irq on every cycle.
module uart_irq_prio_tb;
    localparam int DEPTH = 16;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [6:0]    ien = '0;
    logic [3:0]    lsr_evt = '0, msr_evt = '0;
    logic          rxto_evt = 0, rs485_en = 0, tsr_empty = 0;
    logic [LW-1:0] rx_level = '0, rx_trig = 5'd8, tx_level = 5'd10, tx_trig = 5'd4;
    logic          xoff_det = 0, xon_det = 0, spec_det = 0, rx_char = 0;
    logic          cts_pin = 0, rts_pin = 0, auto_cts = 0, auto_rts = 0;
    logic          isr_rd = 0, lsr_rd = 0, msr_rd = 0, rhr_rd = 0, thr_wr = 0;
    logic [5:0]    isr_code;
    logic          irq;

    int nchk = 0, nerr = 0, cyc = 0;
    bit done = 0;

    // Reference model state
    bit m_line, m_rxto, m_tx, m_msr, m_xoff, m_spec, m_cts, m_rts;
    bit pv_tx, pv_cts, pv_rts;

    always #10 clk = ~clk;

    uart_irq_prio #(.FIFO_DEPTH(DEPTH)) u_dut (.*);

    function automatic logic [5:0] exp_code();
        if (ien[2] && m_line)                         return 6'h06;
        if (ien[0] && m_rxto)                         return 6'h0C;
        if (ien[0] && rx_level >= rx_trig)            return 6'h04;
        if (ien[1] && m_tx)                           return 6'h02;
        if (ien[3] && m_msr)                          return 6'h00;
        if (ien[4] && (m_xoff || m_spec))             return 6'h10;
        if ((ien[6] && m_cts) || (ien[5] && m_rts))   return 6'h20;
        return 6'h01;
    endfunction

    // Advance the model on each rising edge
    always @(posedge clk) begin
        logic [5:0] c;
        bit txc;
        c = exp_code();
        txc = rs485_en ? (tx_level == 0 && tsr_empty) : (tx_level <= tx_trig);
        if (!rst_n) begin
            {m_line, m_rxto, m_tx, m_msr, m_xoff, m_spec, m_cts, m_rts} = '0;
            pv_tx = 1; pv_cts = 1; pv_rts = 1;
        end else begin
            m_line = (lsr_evt != 0) || (m_line && !lsr_rd);
            m_rxto = rxto_evt || (m_rxto && !rhr_rd);
            m_tx   = (txc && !pv_tx) || (m_tx && !thr_wr && !(isr_rd && c == 6'h02));
            m_msr  = (msr_evt != 0) || (m_msr && !msr_rd);
            m_xoff = xoff_det || (m_xoff && !xon_det && !(isr_rd && c == 6'h10));
            m_spec = spec_det || (m_spec && !rx_char && !(isr_rd && c == 6'h10));
            m_cts  = (auto_cts && cts_pin && !pv_cts) || (m_cts && !msr_rd);
            m_rts  = (auto_rts && rts_pin && !pv_rts) || (m_rts && !msr_rd);
            pv_tx = txc; pv_cts = cts_pin; pv_rts = rts_pin;
        end
    end

    // Compare shortly after inputs settle, then wait for the next falling edge
    task automatic step(input string tag);
        logic [5:0] e;
        #2;
        e = exp_code();
        nchk++;
        if (isr_code !== e || irq !== (e != 6'h01)) begin
            nerr++;
            $display("FAIL %s: code=%h irq=%b expected code=%h irq=%b",
                     tag, isr_code, irq, e, (e != 6'h01));
        end
        @(negedge clk);
    endtask

    task automatic quiet();
        lsr_evt = 0; msr_evt = 0; rxto_evt = 0; xoff_det = 0; xon_det = 0;
        spec_det = 0; rx_char = 0; isr_rd = 0; lsr_rd = 0; msr_rd = 0;
        rhr_rd = 0; thr_wr = 0;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            nerr++; nchk++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cyc);
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        ien = 7'h7F;
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1;
        step("R1 reset idle");
        step("R1 reset idle hold");

        // R4 receive level boundaries
        rx_level = 5'd7; step("R4 below trigger");
        rx_level = 5'd8; step("R4 at trigger");
        rx_level = 5'd16; step("R4 full");
        // R5 time-out beats ready
        rxto_evt = 1; step("R5 timeout strobe"); quiet();
        step("R5 timeout over ready");
        rhr_rd = 1; step("R5 holding read"); quiet();
        rx_level = 5'd7; step("R4 fell below");

        // R3 line status and same-cycle set vs read
        lsr_evt = 4'b0100; step("R3 line event"); quiet();
        step("R3 line pending");
        lsr_evt = 4'b0001; lsr_rd = 1; step("R3 event with read"); quiet();
        step("R3 still pending");
        lsr_rd = 1; step("R3 line read"); quiet();
        step("R3 cleared");

        // R6 transmit ready by level edge, cleared by status read
        tx_level = 5'd4; step("R6 level edge"); 
        step("R6 pending");
        isr_rd = 1; step("R6 status read ack"); quiet();
        step("R6 cleared by read");
        tx_level = 5'd5; step("R6 above");
        tx_level = 5'd3; step("R6 second edge");
        thr_wr = 1; step("R6 write clear"); quiet();
        step("R6 cleared by write");

        // R7 status read while line source reported keeps transmit pending
        tx_level = 5'd9; step("R7 prep"); 
        tx_level = 5'd2; lsr_evt = 4'b1000; step("R7 both set"); quiet();
        isr_rd = 1; step("R7 read reports line"); quiet();
        lsr_rd = 1; step("R7 line cleared"); quiet();
        step("R7 transmit still queued");
        thr_wr = 1; step("R7 write"); quiet();

        // R6 half-duplex mode
        rs485_en = 1; tx_level = 5'd0; tsr_empty = 0; step("R6 rs485 shifter busy");
        step("R6 rs485 no edge");
        tsr_empty = 1; step("R6 rs485 shifter empty");
        step("R6 rs485 pending");
        thr_wr = 1; step("R6 rs485 write"); quiet();
        rs485_en = 0; tx_level = 5'd10; step("R6 back to normal");

        // R8 modem
        msr_evt = 4'b0010; step("R8 modem event"); quiet();
        step("R8 pending");
        msr_rd = 1; step("R8 read"); quiet();

        // R9 Xoff and special characters
        xoff_det = 1; step("R9 xoff"); quiet();
        step("R9 xoff pending");
        xon_det = 1; step("R9 xon clears"); quiet();
        spec_det = 1; rx_char = 1; step("R9 special with char"); quiet();
        step("R9 special pending");
        rx_char = 1; step("R9 next char"); quiet();
        xoff_det = 1; spec_det = 1; step("R9 both"); quiet();
        msr_evt = 4'b0001; step("R7 modem above xchr"); quiet();
        isr_rd = 1; step("R7 read reports modem"); quiet();
        step("R7 xchr queued");
        msr_rd = 1; step("R9 modem read"); quiet();
        isr_rd = 1; step("R9 status read ack"); quiet();
        step("R9 cleared");

        // R10 flow-control edges
        cts_pin = 1; step("R10 cts edge without auto");
        step("R10 no source");
        cts_pin = 0; auto_cts = 1; step("R10 cts low");
        cts_pin = 1; step("R10 cts rise");
        step("R10 cts pending");
        msr_rd = 1; step("R10 read"); quiet();
        auto_rts = 1; rts_pin = 1; step("R10 rts rise");
        step("R10 rts pending");
        msr_rd = 1; step("R10 rts read"); quiet();

        // R11 masking and later enable
        ien = 7'b1111011; lsr_evt = 4'b0010; step("R11 masked line"); quiet();
        step("R11 hidden");
        ien = 7'h7F; step("R11 enabled shows");
        lsr_rd = 1; step("R11 clear"); quiet();
        ien = 7'h00; rx_level = 5'd12; step("R11 all masked");
        ien = 7'h01; step("R11 rx enabled");
        rx_level = 5'd0; step("R1 idle again");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule